// File: doc/BRIEF.md
# Byte-Interleaving STS-48 Transmit Multiplexer

This block merges four frame-aligned, byte-wide STS-12-class tributaries into one byte-wide STS-48-class stream. Every fourth cycle the upstream logic presents one byte from each tributary, each with its own parity bit. The block then emits those four bytes over the next four cycles, tributary 0 first. The tributaries must already share a common frame phase, and a start-of-frame strobe comes with the group that carries the first byte of each frame.

While the bytes pass through, the block rewrites the transport overhead of the combined frame:
- The section-trace and growth column of row 0 is overwritten.
- The four tributaries' M1 error counts are summed, capped, and placed in tributary 0's M1 slot. The other three slots are cleared.
- Every STS-1 gets a fresh B2 computed over the frame that now carries the new M1.
- The frame is scrambled, except for its framing and trace bytes.
- B1 is computed over the previous scrambled frame.

Each tributary's parity is checked, and any violation latches a per-tributary error flag. The number of STS-1s per tributary and the columns per STS-1 are parameters, so a short test frame can be used.

Top module: `sts_byte_mux`

## Requirements
- R1: A group sampled on a clock edge with `in_valid` high leaves as four `out_valid` bytes after the following four edges. Byte t of the group is tributary t's byte `in_data[8t+7:8t]`, and the first byte appears after the second edge. Non-overhead bytes come out unchanged apart from scrambling.
- R2: Groups sampled before the first one flagged by `in_sof` produce no output. `in_sof` resets the frame position to row 0, column 0. `out_sof` is high exactly on the output byte at row 0, column 0 of STS-1 index 0.
- R3: In row 0, transport-overhead column 2, output STS-1 index 0 carries `J0_VAL`. Output STS-1 index g > 0 carries g+1. Output STS-1 index g = tributary + 4·(STS-1 within tributary). These bytes are not scrambled.
- R4: The M1 slot is row 8, column 1 of STS-1 `M1_STS` in each tributary. Tributary 0's slot carries the sum of the four tributaries' M1 inputs, capped at `M1_MAX`. The slots of tributaries 1 to 3 carry 0.
- R5: In row 4, column 0, output STS-1 g carries the XOR of all unscrambled bytes of STS-1 g in the previous frame. Rows 0 to 2, columns 0 to 2 are excluded from that XOR. In the first frame after reset this byte is 0.
- R6: In row 1, column 0, output STS-1 index 0 carries the XOR of every scrambled output byte of the previous frame. In the first frame after reset this byte is 0.
- R7: Every byte except row 0, columns 0 to 2 is XORed, MSB first, with the sequence of the generator 1+x^6+x^7. The generator is set to all ones at row 0, column 3, STS-1 index 0, so its first mask byte is 0xFE and its second is 0x04.
- R8: `par_err[t]` rises after a sampled group whose tributary t has an even count of ones over its 8 data bits plus parity bit (with `PAR_ODD`=1). It then stays high until reset.
- R9: During and after reset, `out_valid`, `out_sof` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Group of tributary bytes present (every fourth cycle) |
| in_sof | input | 1 | Group holds the first byte of a frame |
| in_data | input | 8·TRIBS | One byte per tributary, tributary t in bits 8t+7:8t |
| in_par | input | TRIBS | Parity bit per tributary |
| out_data | output | 8 | Interleaved, rewritten, scrambled byte |
| out_valid | output | 1 | `out_data` holds a byte |
| out_sof | output | 1 | Current byte is the first of a frame |
| par_err | output | TRIBS | Sticky per-tributary parity error |

## Verification
The bench drives M1 counts whose sum is below the cap, far above it, exactly at it and one below it.
- A design that wraps the sum or caps it at the wrong value shows a wrong tributary-0 M1 byte.
- A design that leaves the other slots unchanged shows a non-zero M1 in tributaries 1 to 3.

B1 and B2 are compared over several consecutive frames, starting with the first frame, where both must be zero.
- B2 computed after scrambling, or before the M1 rewrite, gives wrong values.
- B1 computed before scrambling gives wrong values.
- B2 that wrongly includes section overhead gives wrong values.

The scrambler seed point and the unscrambled row-0 columns are covered by comparing every byte, so a generator seeded one byte early or late changes the whole payload. Parity errors are injected on two tributaries at different times to show that each flag is independent and stays set.

// File: rtl/stsmux_pkg.sv
// Shared constants and helpers for the STS-48 transmit multiplexer.
// Overhead positions are fixed by the frame layout; the scrambler is the
// frame-synchronous 1+x^6+x^7 generator stepped eight bits per byte.
package stsmux_pkg;

    localparam int FRAME_ROWS = 9;
    localparam int OH_COLS    = 3;
    localparam int ROW_TRACE  = 0;
    localparam int COL_TRACE  = 2;
    localparam int ROW_SBIP   = 1;
    localparam int COL_SBIP   = 0;
    localparam int ROW_LBIP   = 4;
    localparam int COL_LBIP   = 0;
    localparam int ROW_ERRCNT = 8;
    localparam int COL_ERRCNT = 1;

    localparam logic [6:0] SCR_SEED = 7'h7F;

    typedef struct packed {
        logic [7:0] mask;
        logic [6:0] next;
    } scr_step_t;

    // Advance the generator by one byte; mask bit 7 is the first bit out.
    function automatic scr_step_t scr_advance8(input logic [6:0] st);
        scr_step_t  r;
        logic [6:0] s;
        s      = st;
        r.mask = '0;
        for (int i = 7; i >= 0; i--) begin
            r.mask[i] = s[6];
            s         = {s[5:0], s[6] ^ s[5]};
        end
        r.next = s;
        return r;
    endfunction

endpackage

// File: rtl/stsmux_parity.sv
// Per-tributary parity checker with a sticky error flag.
// Assumes: chk is high for exactly the cycles a group is sampled.
module stsmux_parity #(
    parameter bit PAR_ODD = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chk,
    input  logic [7:0] data,
    input  logic       par,
    output logic       err
);

    // Latch an error when a sampled byte breaks the configured parity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (chk && ((^{data, par}) != PAR_ODD))
            err <= 1'b1;
    end

    // R8: once set, the flag holds until reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: the flag only rises after a checked group
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(chk));

endmodule

// File: rtl/stsmux_framepos.sv
// Frame position tracker for the interleaver.
// Loads a group on in_valid once locked to the first in_sof, then walks four
// output lanes. Per group it advances STS-1-within-tributary, then column,
// then row. Assumes groups arrive every TRIBS cycles.
module stsmux_framepos #(
    parameter int TRIBS        = 4,
    parameter int STS_PER_TRIB = 12,
    parameter int COLS_PER_STS = 90,
    localparam int LANE_W = (TRIBS > 1) ? $clog2(TRIBS) : 1,
    localparam int STS_W  = (STS_PER_TRIB > 1) ? $clog2(STS_PER_TRIB) : 1,
    localparam int COL_W  = $clog2(COLS_PER_STS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    output logic              load,
    output logic              act,
    output logic [LANE_W-1:0] lane,
    output logic [3:0]        row,
    output logic [COL_W-1:0]  col,
    output logic [STS_W-1:0]  sts
);
    import stsmux_pkg::*;

    logic locked;

    assign load = in_valid && (locked || in_sof);

    // Lock onto the first frame start and never release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (in_valid && in_sof)
            locked <= 1'b1;
    end

    // Step through the lanes of the current group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            lane <= '0;
        end else if (load) begin
            act  <= 1'b1;
            lane <= '0;
        end else if (act) begin
            if (lane == LANE_W'(TRIBS - 1))
                act <= 1'b0;
            else
                lane <= lane + LANE_W'(1);
        end
    end

    // Move the frame position by one group on every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
            sts <= '0;
        end else if (load) begin
            if (in_sof) begin
                row <= '0;
                col <= '0;
                sts <= '0;
            end else if (sts != STS_W'(STS_PER_TRIB - 1)) begin
                sts <= sts + STS_W'(1);
            end else begin
                sts <= '0;
                if (col != COL_W'(COLS_PER_STS - 1)) begin
                    col <= col + COL_W'(1);
                end else begin
                    col <= '0;
                    row <= (row == 4'(FRAME_ROWS - 1)) ? 4'd0 : row + 4'd1;
                end
            end
        end
    end

    // R1: lanes advance one per cycle within a group
    assert_lane_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        act && !load && lane != LANE_W'(TRIBS - 1) |=> act && lane == $past(lane) + LANE_W'(1));

    // R2: nothing is emitted before the first frame start
    assert_quiet_until_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !act);

    // R2: a frame start returns the position to the frame origin
    assert_sof_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load && in_sof |=> row == 4'd0 && col == '0 && sts == '0);

endmodule

// File: rtl/stsmux_bip.sv
// Bank of BIP-8 accumulators, one per channel.
// At the frame's first byte every accumulator is copied to its hold register
// and restarted; included bytes are XORed into the addressed channel.
module stsmux_bip #(
    parameter int NUM_CH = 1,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic                   first,
    input  logic                   incl,
    input  logic [CH_W-1:0]        ch,
    input  logic [7:0]             d,
    output logic [NUM_CH-1:0][7:0] hold
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [7:0] acc_r;
        logic [7:0] hold_r;
        logic       hit;

        assign hit     = incl && (ch == CH_W'(c));
        assign hold[c] = hold_r;

        // Accumulate this channel's bytes and publish at each frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_r  <= '0;
                hold_r <= '0;
            end else if (step) begin
                if (first) begin
                    hold_r <= acc_r;
                    acc_r  <= hit ? d : 8'h00;
                end else if (hit) begin
                    acc_r <= acc_r ^ d;
                end
            end
        end
    end

    // R5 / R6: published parity only changes at a frame boundary
    assert_hold_frame_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && first) |=> $stable(hold));

endmodule

// File: rtl/stsmux_scrambler.sv
// Frame-synchronous scrambler mask generator.
// seed forces the all-ones state for the current byte; bypass marks bytes
// that are sent in clear and do not advance the sequence.
module stsmux_scrambler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       seed,
    input  logic       bypass,
    output logic [7:0] mask
);
    import stsmux_pkg::*;

    logic [6:0] st;
    scr_step_t  nx;

    // Derive this byte's mask from the running or reseeded state.
    always_comb nx = scr_advance8(seed ? SCR_SEED : st);

    assign mask = nx.mask;

    // Keep the running state for the next scrambled byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= SCR_SEED;
        else if (step && !bypass)
            st <= nx.next;
    end

    // R7: clear bytes leave the sequence where it was
    assert_bypass_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step && bypass |=> $stable(st));

    // R7: the first byte after reseeding is masked with 0xFE
    assert_seed_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step && seed |-> mask == 8'hFE);

endmodule

// File: rtl/sts_byte_mux.sv
// STS-48 transmit multiplexer top.
// Interleaves TRIBS frame-aligned byte tributaries and rewrites the trace
// column, M1, B2 and B1, then scrambles. Assumes groups arrive every TRIBS
// cycles, tributaries are frame aligned, and COLS_PER_STS > 3.
module sts_byte_mux #(
    parameter int         TRIBS        = 4,
    parameter int         STS_PER_TRIB = 12,
    parameter int         COLS_PER_STS = 90,
    parameter int         M1_STS       = 2,
    parameter int         M1_MAX       = 255,
    parameter logic [7:0] J0_VAL       = 8'h01,
    parameter bit         PAR_ODD      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [8*TRIBS-1:0] in_data,
    input  logic [TRIBS-1:0]   in_par,
    output logic [7:0]         out_data,
    output logic               out_valid,
    output logic               out_sof,
    output logic [TRIBS-1:0]   par_err
);
    import stsmux_pkg::*;

    localparam int N_STS  = TRIBS * STS_PER_TRIB;
    localparam int LANE_W = (TRIBS > 1) ? $clog2(TRIBS) : 1;
    localparam int STS_W  = (STS_PER_TRIB > 1) ? $clog2(STS_PER_TRIB) : 1;
    localparam int COL_W  = $clog2(COLS_PER_STS);
    localparam int G_W    = (N_STS > 1) ? $clog2(N_STS) : 1;
    localparam int SUM_W  = 9 + $clog2(TRIBS);

    logic               load, act;
    logic [LANE_W-1:0]  lane;
    logic [3:0]         row;
    logic [COL_W-1:0]   col;
    logic [STS_W-1:0]   sts;
    logic [8*TRIBS-1:0] grp;
    logic [G_W-1:0]     g_idx;
    logic [7:0]         trib_byte, pre, scr_byte, scr_mask, m1_sat;
    logic [SUM_W-1:0]   m1_sum;
    logic               frame_first, sect_oh, row0_oh, seed_here;
    logic [0:0][7:0]    b1_hold;
    logic [N_STS-1:0][7:0] b2_hold;

    for (genvar t = 0; t < TRIBS; t++) begin : g_par
        stsmux_parity #(.PAR_ODD(PAR_ODD)) u_par (
            .clk  (clk),
            .rst_n(rst_n),
            .chk  (in_valid),
            .data (in_data[8*t +: 8]),
            .par  (in_par[t]),
            .err  (par_err[t])
        );
    end

    stsmux_framepos #(
        .TRIBS(TRIBS), .STS_PER_TRIB(STS_PER_TRIB), .COLS_PER_STS(COLS_PER_STS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .load(load), .act(act), .lane(lane), .row(row), .col(col), .sts(sts)
    );

    // Hold the sampled group while its bytes are sent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp <= '0;
        else if (load)
            grp <= in_data;
    end

    assign trib_byte   = grp[8*int'(lane) +: 8];
    assign g_idx       = G_W'(int'(sts) * TRIBS + int'(lane));
    assign frame_first = act && row == 4'd0 && col == '0 && sts == '0 && lane == '0;
    assign sect_oh     = (row < 4'd3) && (col < COL_W'(OH_COLS));
    assign row0_oh     = (row == 4'd0) && (col < COL_W'(OH_COLS));
    assign seed_here   = (row == 4'd0) && (col == COL_W'(OH_COLS)) && (g_idx == '0);

    // Add the M1 counts of all tributaries in the group.
    always_comb begin
        m1_sum = '0;
        for (int t = 0; t < TRIBS; t++)
            m1_sum = m1_sum + SUM_W'(grp[8*t +: 8]);
    end

    assign m1_sat = (m1_sum > SUM_W'(M1_MAX)) ? 8'(M1_MAX) : m1_sum[7:0];

    // Choose the unscrambled byte: tributary data or rewritten overhead.
    always_comb begin
        pre = trib_byte;
        if (row == 4'(ROW_TRACE) && col == COL_W'(COL_TRACE))
            pre = (g_idx == '0) ? J0_VAL : 8'(int'(g_idx) + 1);
        else if (row == 4'(ROW_SBIP) && col == COL_W'(COL_SBIP) && g_idx == '0)
            pre = b1_hold[0];
        else if (row == 4'(ROW_LBIP) && col == COL_W'(COL_LBIP))
            pre = b2_hold[g_idx];
        else if (row == 4'(ROW_ERRCNT) && col == COL_W'(COL_ERRCNT) && sts == STS_W'(M1_STS))
            pre = (lane == '0) ? m1_sat : 8'h00;
    end

    stsmux_bip #(.NUM_CH(N_STS)) u_line_bip (
        .clk(clk), .rst_n(rst_n), .step(act), .first(frame_first),
        .incl(!sect_oh), .ch(g_idx), .d(pre), .hold(b2_hold)
    );

    stsmux_scrambler u_scr (
        .clk(clk), .rst_n(rst_n), .step(act), .seed(seed_here),
        .bypass(row0_oh), .mask(scr_mask)
    );

    assign scr_byte = row0_oh ? pre : (pre ^ scr_mask);

    stsmux_bip #(.NUM_CH(1)) u_sect_bip (
        .clk(clk), .rst_n(rst_n), .step(act), .first(frame_first),
        .incl(1'b1), .ch(1'b0), .d(scr_byte), .hold(b1_hold)
    );

    // Register the outgoing byte and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_data  <= scr_byte;
            out_valid <= act;
            out_sof   <= frame_first;
        end
    end

    // R2: a frame marker only accompanies a real byte
    assert_sof_in_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R4: the consolidated M1 never exceeds its legal maximum
    assert_m1_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act && row == 4'(ROW_ERRCNT) && col == COL_W'(COL_ERRCNT) && sts == STS_W'(M1_STS)
        |-> int'(pre) <= M1_MAX);

    // R3: trace column bytes leave the scrambler untouched
    assert_trace_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act && row == 4'(ROW_TRACE) && col == COL_W'(COL_TRACE) |-> scr_byte == pre);

endmodule

// File: tb/sts_byte_mux_test.sv
module sts_byte_mux_test;

    localparam int CLK_PERIOD = 10;
    localparam int T    = 4;
    localparam int S    = 3;
    localparam int C    = 4;
    localparam int N    = T * S;
    localparam int M1S  = 2;
    localparam int M1MX = 255;
    localparam logic [7:0] J0 = 8'h5A;

    logic           clk = 1'b0;
    logic           rst_n, in_valid, in_sof;
    logic [8*T-1:0] in_data;
    logic [T-1:0]   in_par;
    logic [7:0]     out_data;
    logic           out_valid, out_sof;
    logic [T-1:0]   par_err;

    sts_byte_mux #(
        .TRIBS(T), .STS_PER_TRIB(S), .COLS_PER_STS(C), .M1_STS(M1S),
        .M1_MAX(M1MX), .J0_VAL(J0), .PAR_ODD(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .in_par(in_par), .out_data(out_data),
        .out_valid(out_valid), .out_sof(out_sof), .par_err(par_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    v;
        bit    sof;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    sofq[$];
    int    tests = 0, fails = 0, cyc = 0;
    bit    running = 1'b0, done = 1'b0;

    bit    seq[127];
    int    sidx = 0;
    int    b1acc = 0, b1hold = 0;
    int    b2acc[N], b2hold[N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Reference model: expected output bytes for one group, in output order.
    task automatic model_group(input int row, input int col, input int sts, input int d[T]);
        int sum, sat, g, pre, outb, mask;
        bit first;
        string tag;
        sum = 0;
        for (int t = 0; t < T; t++) sum += d[t];
        sat = (sum > M1MX) ? M1MX : sum;
        for (int t = 0; t < T; t++) begin
            g = sts * T + t;
            pre = d[t];
            tag = "R1/R7";
            if (row == 0 && col < 3) tag = "R1";
            if (row == 0 && col == 2) begin
                pre = (g == 0) ? int'(J0) : g + 1;
                tag = "R3";
            end else if (row == 1 && col == 0 && g == 0) begin
                pre = b1hold;
                tag = "R6";
            end else if (row == 4 && col == 0) begin
                pre = b2hold[g];
                tag = "R5";
            end else if (row == 8 && col == 1 && sts == M1S) begin
                pre = (t == 0) ? sat : 0;
                tag = "R4";
            end
            first = (row == 0 && col == 0 && g == 0);
            if (first) begin
                b1hold = b1acc;
                b1acc = 0;
                for (int k = 0; k < N; k++) begin
                    b2hold[k] = b2acc[k];
                    b2acc[k] = 0;
                end
            end
            if (!(row < 3 && col < 3)) b2acc[g] ^= pre;
            if (row == 0 && col < 3) begin
                outb = pre;
            end else begin
                if (row == 0 && col == 3 && g == 0) sidx = 0;
                mask = 0;
                for (int b = 7; b >= 0; b--) begin
                    mask |= int'(seq[sidx]) << b;
                    sidx = (sidx + 1) % 127;
                end
                outb = pre ^ mask;
            end
            b1acc ^= outb;
            expq.push_back('{outb, first, tag});
        end
    endtask

    task automatic send_group(input bit sof, input logic [8*T-1:0] d, input logic [T-1:0] perr);
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = sof;
        in_data  = d;
        for (int t = 0; t < T; t++) in_par[t] = ~(^d[8*t +: 8]) ^ perr[t];
        if (sof) sofq.push_back(cyc);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic int gen_byte(input int f, input int r, input int c, input int s, input int t);
        int x;
        x = f * 97 + r * 29 + c * 13 + s * 7 + t * 53 + 11;
        x = x ^ (x << 3) ^ (x >> 2);
        return x & 255;
    endfunction

    task automatic send_frame(input int f, input int m1[T], input int err_grp, input logic [T-1:0] err_mask);
        int gi, d[T];
        logic [8*T-1:0] pk;
        gi = 0;
        for (int r = 0; r < 9; r++)
            for (int c = 0; c < C; c++)
                for (int s = 0; s < S; s++) begin
                    for (int t = 0; t < T; t++) begin
                        d[t] = (r == 8 && c == 1 && s == M1S) ? m1[t] : gen_byte(f, r, c, s, t);
                        pk[8*t +: 8] = 8'(d[t]);
                    end
                    model_group(r, c, s, d);
                    send_group(gi == 0, pk, (gi == err_grp) ? err_mask : '0);
                    gi++;
                end
    endtask

    // Compare every output byte against the model queue.
    always @(negedge clk) begin
        if (running && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2", "output with nothing expected", int'(out_data), 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(int'(out_data) == e.v, e.tag, "byte", int'(out_data), e.v);
                check(out_sof == e.sof, "R2", "out_sof", int'(out_sof), int'(e.sof));
                if (out_sof && sofq.size() > 0) begin
                    int s0;
                    s0 = sofq.pop_front();
                    check(cyc == s0 + 2, "R1", "first byte latency", cyc, s0 + 2);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int n = 0; n < 7; n++) seq[n] = 1'b1;
        for (int n = 7; n < 127; n++) seq[n] = seq[n-6] ^ seq[n-7];
        for (int k = 0; k < N; k++) begin
            b2acc[k] = 0;
            b2hold[k] = 0;
        end
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0; in_par = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        check(par_err == '0, "R9", "par_err in reset", int'(par_err), 0);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_sof == 1'b0, "R9", "idle after reset", int'(out_valid), 0);

        // R2: groups before the first frame start are dropped
        for (int i = 0; i < 3; i++) send_group(1'b0, 32'hA5C3_0F11 + 32'(i), '0);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "no output before sync", int'(out_valid), 0);

        send_frame(0, '{1, 2, 3, 4}, -1, '0);
        check(par_err == '0, "R8", "no parity error yet", int'(par_err), 0);
        send_frame(1, '{200, 200, 100, 50}, 20, 4'b0100);
        check(par_err == 4'b0100, "R8", "tributary 2 flag", int'(par_err), 4);
        send_frame(2, '{100, 100, 50, 5}, -1, '0);
        check(par_err == 4'b0100, "R8", "flag stays set", int'(par_err), 4);
        send_frame(3, '{250, 4, 0, 0}, 5, 4'b0001);
        check(par_err == 4'b0101, "R8", "tributary 0 flag added", int'(par_err), 5);
        send_frame(4, '{0, 0, 0, 0}, -1, '0);
        repeat (8) @(negedge clk);
        check(expq.size() == 0, "R1", "all expected bytes emitted", expq.size(), 0);
        finish_run();
    end

endmodule